// File: doc/BRIEF.md
# Load Address Latency Classifier

This block sits beside a load pipeline. It takes a load request made of a base register value, a signed displacement and a tag, and adds the two to form the effective address. It then decides whether an early cache-index lookup, started from the base alone, is still valid. A small non-negative displacement that stays inside the base's 4 KiB page keeps the early lookup and completes in 4 cycles. A larger or negative displacement that stays in the page needs a second lookup and completes in 5 cycles. An address that leaves the page pays a 9-cycle penalty.

The block accepts one request per clock, and many loads can be in flight at once. Each load is parked in a nine-slot delay line at the position matching its due cycle. A completion pulse then returns the tag, the effective address and the latency class. When two loads would finish in the same cycle, the one accepted first keeps its slot. The later one moves to the next free cycle.

Top module: `ld_fastpath`

## Requirements
- R1: `done_addr` equals `req_base` plus `req_disp` sign-extended to 64 bits, modulo 2^64.
- R2: A load whose displacement lies in 0..2047 and whose effective address stays in the base's 4 KiB page (bits 63:12 unchanged) gets class 0. This includes a zero displacement.
- R3: A load whose effective address stays in the page but whose displacement is 2048 or more, or negative, gets class 1.
- R4: A load whose effective address bits 63:12 differ from the base's gets class 2, whatever its displacement. This class wins over the other two.
- R5: A load accepted at clock edge k with no contention raises `done_valid` for one cycle after edge k+L, carrying its own tag. L is 4, 5 or 9 for class 0, 1 or 2.
- R6: A request is accepted on every edge where `req_valid` is high, with no stall. Every accepted load completes exactly once while several are outstanding.
- R7: If a load's due cycle is already taken by a load accepted earlier, it completes in the first later cycle that is free. Earlier-accepted loads are never moved.
- R8: Asserting `rst_n` low discards every in-flight load. `done_valid` is low during reset and in the first cycle after release.
- R9: `done_class` never shows the value 3 while `done_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_base | input | 64 | Base register value |
| req_disp | input | 32 | Signed displacement |
| req_tag | input | 6 | Request identifier |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | 6 | Tag of the completing load |
| done_addr | output | 64 | Effective address of the completing load |
| done_class | output | 2 | 0 = 4 cycles, 1 = 5 cycles, 2 = 9 cycles |

## Verification
A load driven before edge k shows up on the outputs just after edge k+4, k+5 or k+9. Two registers lie on that path: its slot in the delay line and the output stage. A reference model in the bench keeps a table indexed by edge number. For each accepted load it computes the class from base and displacement, then books the first free entry at or after k+L. The outputs are sampled on the falling edge and compared against the entry for the edge just passed. A completion that arrives early, late, twice or unbooked is reported against the latency, collision or reset requirement. The class and address fields are checked against the requirements that define them.

// File: rtl/ld_fastpath_pkg.sv
package ld_fastpath_pkg;

  typedef enum logic [1:0] {
    LC_FAST = 2'd0,
    LC_MID  = 2'd1,
    LC_PAGE = 2'd2
  } lat_class_e;

endpackage

// File: rtl/ld_fastpath_agen.sv
module ld_fastpath_agen
  import ld_fastpath_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32,
  parameter int PAGE_W = 12,
  parameter int FAST_W = 11
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o,
  output lat_class_e        cls_o
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic              page_moved;
  logic              disp_small;

  always_comb begin
    disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    ea_o       = base_i + disp_ext;
    page_moved = (ea_o[ADDR_W-1:PAGE_W] != base_i[ADDR_W-1:PAGE_W]);
    disp_small = !disp_i[DISP_W-1] && (disp_i[DISP_W-2:FAST_W] == '0);
    if (page_moved)
      cls_o = LC_PAGE;
    else if (disp_small)
      cls_o = LC_FAST;
    else
      cls_o = LC_MID;
  end

endmodule

// File: rtl/ld_fastpath_sched.sv
module ld_fastpath_sched
  import ld_fastpath_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int TAG_W    = 6,
  parameter int LAT_FAST = 4,
  parameter int LAT_MID  = 5,
  parameter int LAT_PAGE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [ADDR_W-1:0] in_addr,
  input  lat_class_e        in_cls,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_addr,
  output lat_class_e        out_cls
);

  localparam int DEPTH = LAT_PAGE;
  localparam int IDX_W = $clog2(DEPTH);

  logic              s_vld_q  [DEPTH];
  logic [TAG_W-1:0]  s_tag_q  [DEPTH];
  logic [ADDR_W-1:0] s_addr_q [DEPTH];
  lat_class_e        s_cls_q  [DEPTH];

  logic              s_vld_d  [DEPTH];
  logic [TAG_W-1:0]  s_tag_d  [DEPTH];
  logic [ADDR_W-1:0] s_addr_d [DEPTH];
  lat_class_e        s_cls_d  [DEPTH];

  logic [DEPTH-1:0]  nxt_occ;
  logic [IDX_W-1:0]  pick;
  logic              found;
  int                lat_m1;

  // earliest slot for the incoming load
  always_comb begin
    case (in_cls)
      LC_FAST: lat_m1 = LAT_FAST - 1;
      LC_MID:  lat_m1 = LAT_MID - 1;
      default: lat_m1 = LAT_PAGE - 1;
    endcase
  end

  // occupancy after this edge's shift
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_occ
      if (g < DEPTH - 1) begin : g_mid
        assign nxt_occ[g] = s_vld_q[g+1];
      end else begin : g_top
        assign nxt_occ[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (j >= lat_m1 && !nxt_occ[j]) begin
        pick  = IDX_W'(j);
        found = 1'b1;
      end
    end
  end

  // next state: shift down, drop the new load into its slot
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      if (j < DEPTH - 1) begin
        s_vld_d[j]  = s_vld_q[j+1];
        s_tag_d[j]  = s_tag_q[j+1];
        s_addr_d[j] = s_addr_q[j+1];
        s_cls_d[j]  = s_cls_q[j+1];
      end else begin
        s_vld_d[j]  = 1'b0;
        s_tag_d[j]  = s_tag_q[j];
        s_addr_d[j] = s_addr_q[j];
        s_cls_d[j]  = s_cls_q[j];
      end
      if (in_valid && found && (int'(pick) == j)) begin
        s_vld_d[j]  = 1'b1;
        s_tag_d[j]  = in_tag;
        s_addr_d[j] = in_addr;
        s_cls_d[j]  = in_cls;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) s_vld_q[j] <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      for (int j = 0; j < DEPTH; j++) s_vld_q[j] <= s_vld_d[j];
      out_valid <= s_vld_q[0];
    end
  end

  // payload: no reset, loaded only when the slot holds a live load
  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (s_vld_d[j]) begin
        s_tag_q[j]  <= s_tag_d[j];
        s_addr_q[j] <= s_addr_d[j];
        s_cls_q[j]  <= s_cls_d[j];
      end
    end
    if (s_vld_q[0]) begin
      out_tag  <= s_tag_q[0];
      out_addr <= s_addr_q[0];
      out_cls  <= s_cls_q[0];
    end
  end

  // R7
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (found && !nxt_occ[pick]));

  // R5
  min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(pick) >= lat_m1));

endmodule

// File: rtl/ld_fastpath.sv
module ld_fastpath
  import ld_fastpath_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 32,
  parameter int TAG_W    = 6,
  parameter int PAGE_W   = 12,
  parameter int FAST_W   = 11,
  parameter int LAT_FAST = 4,
  parameter int LAT_MID  = 5,
  parameter int LAT_PAGE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic [ADDR_W-1:0] done_addr,
  output logic [1:0]        done_class
);

  logic [ADDR_W-1:0] a_ea;
  lat_class_e        a_cls;
  lat_class_e        o_cls;

  ld_fastpath_agen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .PAGE_W (PAGE_W),
    .FAST_W (FAST_W)
  ) u_agen (
    .base_i (req_base),
    .disp_i (req_disp),
    .ea_o   (a_ea),
    .cls_o  (a_cls)
  );

  // R2
  fast_same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && a_cls == LC_FAST) |->
      (a_ea[ADDR_W-1:PAGE_W] == req_base[ADDR_W-1:PAGE_W] && a_ea >= req_base));

  // R4
  page_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && a_ea[ADDR_W-1:PAGE_W] != req_base[ADDR_W-1:PAGE_W]) |->
      (a_cls == LC_PAGE));

  ld_fastpath_sched #(
    .ADDR_W   (ADDR_W),
    .TAG_W    (TAG_W),
    .LAT_FAST (LAT_FAST),
    .LAT_MID  (LAT_MID),
    .LAT_PAGE (LAT_PAGE)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_tag    (req_tag),
    .in_addr   (a_ea),
    .in_cls    (a_cls),
    .out_valid (done_valid),
    .out_tag   (done_tag),
    .out_addr  (done_addr),
    .out_cls   (o_cls)
  );

  assign done_class = o_cls;

  // R9
  class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_class != 2'd3));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> !done_valid);

endmodule

// File: tb/ld_fastpath_bench.sv
`timescale 1ns/1ps
module ld_fastpath_bench;

  localparam int MAXC = 4096;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_base;
  logic [31:0] req_disp;
  logic [5:0]  req_tag;
  logic        done_valid;
  logic [5:0]  done_tag;
  logic [63:0] done_addr;
  logic [1:0]  done_class;

  ld_fastpath u_ld_fastpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_base   (req_base),
    .req_disp   (req_disp),
    .req_tag    (req_tag),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .done_addr  (done_addr),
    .done_class (done_class)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  int seen   = 0;

  logic        exp_v   [MAXC];
  logic        exp_dly [MAXC];
  logic [5:0]  exp_tag [MAXC];
  logic [63:0] exp_addr[MAXC];
  logic [1:0]  exp_cls [MAXC];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [1:0] ref_cls(input logic [63:0] b, input logic [31:0] d);
    logic [63:0] ea;
    ea = b + {{32{d[31]}}, d};
    if (ea[63:12] != b[63:12]) return 2'd2;
    if ($signed(d) >= 0 && $signed(d) < 2048) return 2'd0;
    return 2'd1;
  endfunction

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 5 : 9;
  endfunction

  function automatic string cls_req(input logic [1:0] c);
    return (c == 2'd0) ? "R2" : (c == 2'd1) ? "R3" : "R4";
  endfunction

  // monitor: compare against the booking for the edge just passed
  always @(negedge clk) begin
    if (!rst_n) begin
      if (done_valid) chk(1'b0, "R8", "done during reset", 64'(done_valid), 64'd0);
    end else if (cyc < MAXC) begin
      if (done_valid) seen++;
      if (exp_v[cyc]) begin
        chk(done_valid === 1'b1, exp_dly[cyc] ? "R7" : "R5", "completion missing",
            64'(done_valid), 64'd1);
        if (done_valid === 1'b1) begin
          chk(done_tag == exp_tag[cyc], exp_dly[cyc] ? "R7" : "R5", "tag",
              64'(done_tag), 64'(exp_tag[cyc]));
          chk(done_addr == exp_addr[cyc], "R1", "address", done_addr, exp_addr[cyc]);
          chk(done_class == exp_cls[cyc], cls_req(exp_cls[cyc]), "class",
              64'(done_class), 64'(exp_cls[cyc]));
          chk(done_class != 2'd3, "R9", "class code", 64'(done_class), 64'd0);
        end
      end else if (done_valid) begin
        chk(1'b0, "R5", "unbooked completion", 64'(done_tag), 64'd0);
      end
    end
  end

  task automatic issue(input logic [63:0] b, input logic [31:0] d, input logic [5:0] t);
    int k;
    int c;
    logic [1:0] cl;
    @(negedge clk);
    req_valid = 1'b1;
    req_base  = b;
    req_disp  = d;
    req_tag   = t;
    k  = cyc + 1;
    cl = ref_cls(b, d);
    c  = k + lat_of(cl);
    while (exp_v[c]) c++;
    exp_v[c]    = 1'b1;
    exp_dly[c]  = (c != k + lat_of(cl));
    exp_tag[c]  = t;
    exp_addr[c] = b + {{32{d[31]}}, d};
    exp_cls[c]  = cl;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_and_count(input int issued, input int seen0);
    idle(14);
    chk((seen - seen0) == issued, "R6", "completions seen", 64'(seen - seen0), 64'(issued));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_valid == 1'b0, "R8", "valid in reset", 64'(done_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_valid == 1'b0, "R8", "valid after release", 64'(done_valid), 64'd0);
  endtask

  task automatic t_fast();
    int s0 = seen;
    issue(64'h0000_1000_0000_0040, 32'd0, 6'd1);       // zero disp, R2
    idle(6);
    issue(64'h0000_2000_0000_3000, 32'd2047, 6'd2);    // 2047, no carry, R2
    idle(6);
    issue(64'h0000_2000_0000_37F0, 32'd15, 6'd3);      // small, reaches 0x37FF, R2
    drain_and_count(3, s0);
  endtask

  task automatic t_mid();
    int s0 = seen;
    issue(64'h0000_0000_0000_5000, 32'd2048, 6'd4);    // 2048 same page, R3
    idle(7);
    issue(64'h0000_0000_0000_5010, 32'hFFFF_FFFF, 6'd5); // -1 no borrow, R3
    idle(7);
    issue(64'h0000_0000_0000_5FFF, 32'hFFFF_F801, 6'd6); // -2047 same page, R3
    drain_and_count(3, s0);
  endtask

  task automatic t_page();
    int s0 = seen;
    issue(64'h0000_0000_0000_6000, 32'hFFFF_FFFF, 6'd7); // -1 with borrow, R4
    idle(10);
    issue(64'h0000_0000_0000_6900, 32'd2047, 6'd8);      // small carry into bit 12, R4
    idle(10);
    issue(64'h0000_0000_0000_7000, 32'h7FFF_FFFF, 6'd9); // large positive, R4
    idle(10);
    issue(64'h0000_0000_0000_0010, 32'h8000_0000, 6'd10); // wraps below zero, R1 R4
    drain_and_count(4, s0);
  endtask

  task automatic t_collision();
    int s0 = seen;
    issue(64'h0000_0000_0000_8000, 32'd2048, 6'd11);   // 5 cycles
    issue(64'h0000_0000_0000_9000, 32'd8, 6'd12);      // 4 cycles, same due: R7 delay
    issue(64'h0000_0000_0000_A000, 32'd8, 6'd13);      // bumped again, R7
    drain_and_count(3, s0);
  endtask

  task automatic t_stream();
    int s0 = seen;
    // five page crossers then a run of fast loads: cascade of R7 delays, R6 back-to-back
    for (int i = 0; i < 5; i++)
      issue(64'h0000_0000_0001_0000 + 64'(i * 64), 32'hFFFF_FF00, 6'(20 + i));
    for (int i = 0; i < 8; i++)
      issue(64'h0000_0000_0002_0000 + 64'(i * 8), 32'(i * 100), 6'(30 + i));
    for (int i = 0; i < 6; i++)
      issue(64'h0000_0000_0003_0800, (i % 2 == 0) ? 32'd2100 : 32'd16, 6'(40 + i));
    drain_and_count(19, s0);
  endtask

  task automatic t_reset_flush();
    issue(64'h0000_0000_0004_0000, 32'hFFFF_FFF0, 6'd50); // 9-cycle load
    issue(64'h0000_0000_0004_1000, 32'd4, 6'd51);
    idle(1);
    rst_n = 1'b0;
    for (int c = 0; c < MAXC; c++) exp_v[c] = 1'b0;
    @(negedge clk);
    chk(done_valid == 1'b0, "R8", "valid in reset", 64'(done_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_valid == 1'b0, "R8", "valid after release", 64'(done_valid), 64'd0);
    idle(12); // monitor reports any stale completion
  endtask

  initial begin
    for (int c = 0; c < MAXC; c++) begin
      exp_v[c]   = 1'b0;
      exp_dly[c] = 1'b0;
    end
    req_valid = 1'b0;
    req_base  = '0;
    req_disp  = '0;
    req_tag   = '0;
    t_reset();
    t_fast();
    t_mid();
    t_page();
    t_collision();
    t_stream();
    t_reset_flush();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3500) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule